// File: doc/BRIEF.md
# Interrupt Entry Address Generator

When the interrupt controller accepts a request, this block works out where the handler starts and which register bank the handler runs in. The request carries a node number, a priority level from 0 to 15 and a group level from 0 to 7. The address comes from one of two sources. The first is a vector table whose slot spacing is set by software. The second is one of two fast entries, which hold a complete 24-bit handler address and bypass the table for top-priority requests.

The block also reads a bank map, indexed by level and group. For levels 12 to 15 this map selects the global bank or one of two local banks. Results are captured at acceptance and held. A one-cycle ready strobe follows after a fixed latency, and that latency is shorter when a fast entry supplied the address. While a result is pending, the block shows busy and turns away new requests.

Configuration is written through a small address/data/write-enable port. Every configuration register resets to zero.

Top module: `intr_entry_gen`

## Requirements
- R1: After reset, busy, entry_ready, entry_addr, entry_fast and entry_bank are all 0. Every fast entry is disabled and the table spacing is 2 words.
- R2: Without a fast hit, entry_addr equals ({base segment at cfg 1 bits 7:0, base offset at cfg 0} + node × (4 << scale)) modulo 2^24, with entry_fast = 0. The address is in bytes. Scale sits at cfg 2 bits 1:0, and scale values 0, 1, 2 and 3 give spacings of 2, 4, 8 and 16 words.
- R3: Fast entry k is programmed through three registers. Register 3+3k holds the enable in bit 15 and the segment in bits 7:0. Register 4+3k holds the offset. Register 5+3k holds the served level in bits 3:0 and the served group in bits 6:4. The entry hits when it is enabled and both level and group match the request. On a hit, entry_addr = {segment, offset} and entry_fast = 1.
- R4: A request with level below 12 never takes a fast entry, even when an enabled entry's tag matches it.
- R5: When both fast entries hit, entry 0 supplies the address.
- R6: Cfg registers 9 to 12 hold the bank map for levels 12 to 15. Group g uses field bits 2g+1:2g. Field value 2 selects local bank 1 (entry_bank = 1). Field value 3 selects local bank 2 (entry_bank = 2). Field values 0 and 1 select the global bank (entry_bank = 0). Requests below level 12 always get entry_bank = 0.
- R7: Suppose a request is accepted at clock edge t. entry_ready is then high for exactly one cycle, starting at edge t+19 for a fast hit and at edge t+23 otherwise.
- R8: busy goes high at the accepting edge and stays high through the ready cycle. A req_valid seen while busy is high is ignored and produces no strobe.
- R9: The outputs keep the values captured at acceptance until the strobe ends. Configuration writes made while a result is pending do not alter that result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 4 | Configuration register index |
| cfg_wdata | input | 16 | Configuration write data |
| req_valid | input | 1 | Accepted interrupt request |
| req_node | input | 7 | Interrupt node number |
| req_level | input | 4 | Priority level |
| req_group | input | 3 | Group level |
| busy | output | 1 | Result pending; requests ignored |
| entry_ready | output | 1 | One-cycle result strobe |
| entry_addr | output | 24 | Handler entry address |
| entry_fast | output | 1 | Address came from a fast entry |
| entry_bank | output | 2 | 0 global, 1 local 1, 2 local 2 |

## Verification
The table path runs at every spacing, with a base offset near the top of its range, so a carry into the segment byte would expose a truncated sum. Fast entries are tried four ways: a clean match, a group mismatch, a double match, and a disabled entry 0. Together these separate the enable, tag-compare and priority terms, and a matching tag at level 11 shows the level gate on its own. The bank map is probed with every field code, at the lowest and highest level and group positions. A request and a configuration write are both issued during a pending result, which shows whether busy blocks new requests and whether the captured outputs stay frozen.

// File: rtl/intr_entry_pkg.sv
package intr_entry_pkg;
  localparam int ADDR_W   = 24;
  localparam int SEG_W    = 8;
  localparam int OFF_W    = 16;
  localparam int DATA_W   = 16;
  localparam int HI_LEVEL = 12;
  localparam int N_HI_LVL = 16 - HI_LEVEL;

  typedef enum logic [1:0] {
    BANK_GLOBAL = 2'd0,
    BANK_LOCAL1 = 2'd1,
    BANK_LOCAL2 = 2'd2
  } bank_e;

  typedef struct packed {
    logic             en;
    logic [SEG_W-1:0] seg;
    logic [OFF_W-1:0] off;
    logic [3:0]       lvl;
    logic [2:0]       grp;
  } fast_cfg_t;
endpackage

// File: rtl/intr_cfg_regs.sv
module intr_cfg_regs
  import intr_entry_pkg::*;
#(
  parameter int NUM_FAST = 2,
  parameter int CFG_AW   = 4
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              we,
  input  logic [CFG_AW-1:0]                 addr,
  input  logic [DATA_W-1:0]                 wdata,
  output logic [SEG_W-1:0]                  base_seg,
  output logic [OFF_W-1:0]                  base_off,
  output logic [1:0]                        scale,
  output fast_cfg_t [NUM_FAST-1:0]          fe,
  output logic [N_HI_LVL-1:0][DATA_W-1:0]   bank_map
);
  localparam int A_BOFF = 0;
  localparam int A_BSEG = 1;
  localparam int A_SCL  = 2;
  localparam int A_FE   = 3;
  localparam int A_BANK = A_FE + 3 * NUM_FAST;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_seg <= '0;
      base_off <= '0;
      scale    <= '0;
    end else if (we) begin
      if (addr == CFG_AW'(A_BOFF)) base_off <= wdata;
      if (addr == CFG_AW'(A_BSEG)) base_seg <= wdata[SEG_W-1:0];
      if (addr == CFG_AW'(A_SCL))  scale    <= wdata[1:0];
    end
  end

  for (genvar k = 0; k < NUM_FAST; k++) begin : g_fast
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        fe[k] <= '0;
      end else if (we) begin
        if (addr == CFG_AW'(A_FE + 3*k)) begin
          fe[k].en  <= wdata[15];
          fe[k].seg <= wdata[SEG_W-1:0];
        end
        if (addr == CFG_AW'(A_FE + 3*k + 1)) fe[k].off <= wdata;
        if (addr == CFG_AW'(A_FE + 3*k + 2)) begin
          fe[k].lvl <= wdata[3:0];
          fe[k].grp <= wdata[6:4];
        end
      end
    end
  end

  for (genvar l = 0; l < N_HI_LVL; l++) begin : g_bank
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  bank_map[l] <= '0;
      else if (we && addr == CFG_AW'(A_BANK + l))  bank_map[l] <= wdata;
    end
  end
endmodule

// File: rtl/intr_addr_calc.sv
module intr_addr_calc
  import intr_entry_pkg::*;
#(
  parameter int NUM_FAST = 2,
  parameter int NODE_W   = 7
) (
  input  logic [SEG_W-1:0]                 base_seg,
  input  logic [OFF_W-1:0]                 base_off,
  input  logic [1:0]                       scale,
  input  fast_cfg_t [NUM_FAST-1:0]         fe,
  input  logic [N_HI_LVL-1:0][DATA_W-1:0]  bank_map,
  input  logic [NODE_W-1:0]                req_node,
  input  logic [3:0]                       req_level,
  input  logic [2:0]                       req_group,
  output logic [ADDR_W-1:0]                addr,
  output logic                             fast,
  output bank_e                            bank
);
  localparam int LI_W = (N_HI_LVL > 1) ? $clog2(N_HI_LVL) : 1;

  logic                 hi_lvl;
  logic [NUM_FAST-1:0]  hit;
  logic [ADDR_W-1:0]    tbl_addr;
  logic [ADDR_W-1:0]    fast_addr;
  logic [LI_W-1:0]      lvl_idx;
  logic [1:0]           code;

  assign hi_lvl  = (req_level >= 4'(HI_LEVEL));
  assign lvl_idx = LI_W'(req_level - 4'(HI_LEVEL));

  always_comb begin
    tbl_addr = {base_seg, base_off} + (ADDR_W'(req_node) << (5'(scale) + 5'd2));
  end

  for (genvar k = 0; k < NUM_FAST; k++) begin : g_hit
    assign hit[k] = hi_lvl && fe[k].en && (fe[k].lvl == req_level) && (fe[k].grp == req_group);
  end

  always_comb begin
    fast_addr = '0;
    for (int k = NUM_FAST - 1; k >= 0; k--) begin
      if (hit[k]) fast_addr = {fe[k].seg, fe[k].off};
    end
    fast = |hit;
    addr = fast ? fast_addr : tbl_addr;
  end

  always_comb begin
    code = bank_map[lvl_idx][{req_group, 1'b0} +: 2];
    bank = BANK_GLOBAL;
    if (hi_lvl) begin
      case (code)
        2'b10:   bank = BANK_LOCAL1;
        2'b11:   bank = BANK_LOCAL2;
        default: bank = BANK_GLOBAL;
      endcase
    end
  end
endmodule

// File: rtl/intr_latency_timer.sv
module intr_latency_timer #(
  parameter int LAT_FAST  = 19,
  parameter int LAT_TABLE = 23
) (
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic fast,
  output logic busy,
  output logic ready
);
  localparam int CNT_W = $clog2(LAT_TABLE + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             busy_d, ready_d;

  always_comb begin
    cnt_d   = cnt_q;
    busy_d  = busy;
    ready_d = 1'b0;
    if (accept) begin
      busy_d = 1'b1;
      cnt_d  = fast ? CNT_W'(LAT_FAST - 1) : CNT_W'(LAT_TABLE - 1);
    end else if (ready) begin
      busy_d = 1'b0;
    end else if (busy) begin
      if (cnt_q != '0) cnt_d   = cnt_q - 1'b1;
      else             ready_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      busy  <= 1'b0;
      ready <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      busy  <= busy_d;
      ready <= ready_d;
    end
  end

  AST_READY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> !ready); // R7
  AST_READY_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> busy); // R8
  AST_BUSY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> !busy); // R8
endmodule

// File: rtl/intr_entry_gen.sv
module intr_entry_gen
  import intr_entry_pkg::*;
#(
  parameter int NUM_FAST  = 2,
  parameter int NODE_W    = 7,
  parameter int CFG_AW    = 4,
  parameter int LAT_FAST  = 19,
  parameter int LAT_TABLE = 23
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [CFG_AW-1:0]   cfg_addr,
  input  logic [15:0]         cfg_wdata,
  input  logic                req_valid,
  input  logic [NODE_W-1:0]   req_node,
  input  logic [3:0]          req_level,
  input  logic [2:0]          req_group,
  output logic                busy,
  output logic                entry_ready,
  output logic [23:0]         entry_addr,
  output logic                entry_fast,
  output logic [1:0]          entry_bank
);
  logic rst_s1, rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1  <= 1'b0;
      rst_i_n <= 1'b0;
    end else begin
      rst_s1  <= 1'b1;
      rst_i_n <= rst_s1;
    end
  end

  logic [SEG_W-1:0]                 base_seg;
  logic [OFF_W-1:0]                 base_off;
  logic [1:0]                       scale;
  fast_cfg_t [NUM_FAST-1:0]         fe;
  logic [N_HI_LVL-1:0][DATA_W-1:0]  bank_map;

  intr_cfg_regs #(.NUM_FAST(NUM_FAST), .CFG_AW(CFG_AW)) u_cfg (
    .clk(clk), .rst_n(rst_i_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .base_seg(base_seg), .base_off(base_off), .scale(scale), .fe(fe), .bank_map(bank_map)
  );

  logic [ADDR_W-1:0] calc_addr;
  logic              calc_fast;
  bank_e             calc_bank;

  intr_addr_calc #(.NUM_FAST(NUM_FAST), .NODE_W(NODE_W)) u_calc (
    .base_seg(base_seg), .base_off(base_off), .scale(scale), .fe(fe), .bank_map(bank_map),
    .req_node(req_node), .req_level(req_level), .req_group(req_group),
    .addr(calc_addr), .fast(calc_fast), .bank(calc_bank)
  );

  logic accept;
  assign accept = req_valid && !busy;

  logic [ADDR_W-1:0] addr_d;
  logic              fast_d;
  logic [1:0]        bank_d;

  always_comb begin
    addr_d = entry_addr;
    fast_d = entry_fast;
    bank_d = entry_bank;
    if (accept) begin
      addr_d = calc_addr;
      fast_d = calc_fast;
      bank_d = calc_bank;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      entry_addr <= '0;
      entry_fast <= 1'b0;
      entry_bank <= '0;
    end else begin
      entry_addr <= addr_d;
      entry_fast <= fast_d;
      entry_bank <= bank_d;
    end
  end

  intr_latency_timer #(.LAT_FAST(LAT_FAST), .LAT_TABLE(LAT_TABLE)) u_timer (
    .clk(clk), .rst_n(rst_i_n), .accept(accept), .fast(calc_fast),
    .busy(busy), .ready(entry_ready)
  );

  // Cycle counter since acceptance, used to check the strobe latency
  logic [7:0] age_q;
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n)    age_q <= '0;
    else if (accept) age_q <= '0;
    else if (busy)   age_q <= age_q + 8'd1;
  end

  AST_STROBE_LATENCY: assert property (@(posedge clk) disable iff (!rst_i_n)
    entry_ready |-> (age_q == (entry_fast ? 8'(LAT_FAST) : 8'(LAT_TABLE)))); // R7
  AST_HELD_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_i_n)
    (busy && !entry_ready) |=> ($stable(entry_addr) && $stable(entry_fast) && $stable(entry_bank))); // R9
  AST_LOW_LEVEL_PLAIN: assert property (@(posedge clk) disable iff (!rst_i_n)
    (accept && req_level < 4'(HI_LEVEL)) |=> (!entry_fast && entry_bank == 2'd0)); // R4
  AST_BANK_CODE: assert property (@(posedge clk) disable iff (!rst_i_n)
    entry_bank != 2'b11); // R6
  AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (!rst_i_n)
    (req_valid && busy && !entry_ready) |=> busy); // R8
endmodule

// File: tb/intr_entry_gen_test.sv
module intr_entry_gen_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [3:0]  cfg_addr;
  logic [15:0] cfg_wdata;
  logic        req_valid;
  logic [6:0]  req_node;
  logic [3:0]  req_level;
  logic [2:0]  req_group;
  logic        busy, entry_ready, entry_fast;
  logic [23:0] entry_addr;
  logic [1:0]  entry_bank;

  always #5 clk = ~clk;

  intr_entry_gen uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_node(req_node), .req_level(req_level), .req_group(req_group),
    .busy(busy), .entry_ready(entry_ready), .entry_addr(entry_addr),
    .entry_fast(entry_fast), .entry_bank(entry_bank)
  );

  typedef struct {
    logic [23:0] addr;
    logic        fast;
    logic [1:0]  bank;
    int          cyc;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int   cyc = 0;
  int   checks = 0;
  int   errors = 0;
  bit   done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // Monitor: pops the scoreboard on every strobe
  always @(negedge clk) begin
    if (rst_n && entry_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R8", "unexpected strobe", 32'(entry_addr), 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(entry_addr == e.addr, e.tag, "entry_addr", 32'(entry_addr), 32'(e.addr));
        check(entry_fast == e.fast, e.tag, "entry_fast", 32'(entry_fast), 32'(e.fast));
        check(entry_bank == e.bank, e.tag, "entry_bank", 32'(entry_bank), 32'(e.bank));
        check(cyc == e.cyc, "R7", "strobe cycle", 32'(cyc), 32'(e.cyc));
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Driver: issue a request and push the expected result
  task automatic issue(input logic [6:0] node, input logic [3:0] lvl, input logic [2:0] grp,
                       input logic [23:0] ea, input logic ef, input logic [1:0] eb,
                       input string tag);
    exp_t e;
    @(negedge clk);
    req_valid = 1'b1; req_node = node; req_level = lvl; req_group = grp;
    e.addr = ea; e.fast = ef; e.bank = eb; e.tag = tag;
    e.cyc  = cyc + 1 + (ef ? 19 : 23);
    exp_q.push_back(e);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic drain();
    @(negedge clk);
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (exp_q.size() != 0) check(1'b0, "R7", "missing strobes", 32'(exp_q.size()), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    while (cyc < 20000 && !done) @(posedge clk);
    if (!done) begin
      check(1'b0, "R7", "watchdog expired", 32'(cyc), 0);
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    req_valid = 1'b0; req_node = '0; req_level = '0; req_group = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check(busy == 0, "R1", "busy", 32'(busy), 0);
    check(entry_ready == 0, "R1", "entry_ready", 32'(entry_ready), 0);
    check(entry_addr == 0, "R1", "entry_addr", 32'(entry_addr), 0);
    check(entry_fast == 0 && entry_bank == 0, "R1", "fast/bank", {30'd0, entry_bank} | 32'(entry_fast), 0);

    // R1 R2: default spacing 2 words, zero base
    issue(7'd5, 4'd3, 3'd1, 24'd20, 1'b0, 2'd0, "R1");
    drain();

    // R2: base with carry into segment, spacing 4/16/8 words
    wr(4'd0, 16'hFFF0);
    wr(4'd1, 16'h0012);
    wr(4'd2, 16'h0001);
    issue(7'd4, 4'd8, 3'd0, 24'h130010, 1'b0, 2'd0, "R2");
    drain();
    wr(4'd2, 16'h0003);
    issue(7'd3, 4'd8, 3'd0, 24'h130050, 1'b0, 2'd0, "R2");
    drain();
    wr(4'd2, 16'h0002);
    issue(7'd127, 4'd8, 3'd0, 24'h1307E0, 1'b0, 2'd0, "R2");
    drain();

    // R3: fast entry 0 hit, level 13 group 2
    wr(4'd3, 16'h8034);
    wr(4'd4, 16'h1234);
    wr(4'd5, 16'h002D);
    issue(7'd9, 4'd13, 3'd2, 24'h341234, 1'b1, 2'd0, "R3");
    drain();
    // R3: group mismatch falls back to table
    issue(7'd9, 4'd13, 3'd3, 24'h130080, 1'b0, 2'd0, "R3");
    drain();

    // R5: both entries match, entry 0 wins
    wr(4'd6, 16'h8056);
    wr(4'd7, 16'hABCD);
    wr(4'd8, 16'h002D);
    issue(7'd9, 4'd13, 3'd2, 24'h341234, 1'b1, 2'd0, "R5");
    drain();
    // R3: entry 0 disabled, entry 1 serves
    wr(4'd3, 16'h0034);
    issue(7'd9, 4'd13, 3'd2, 24'h56ABCD, 1'b1, 2'd0, "R3");
    drain();

    // R4: enabled entry tagged level 11 does not hit
    wr(4'd3, 16'h8077);
    wr(4'd5, 16'h000B);
    issue(7'd1, 4'd11, 3'd0, 24'h130000, 1'b0, 2'd0, "R4");
    drain();

    // R6: bank map codes
    wr(4'd9, 16'h0002);
    issue(7'd2, 4'd12, 3'd0, 24'h130010, 1'b0, 2'd1, "R6");
    drain();
    wr(4'd12, 16'hC004);
    issue(7'd2, 4'd15, 3'd7, 24'h130010, 1'b0, 2'd2, "R6");
    drain();
    issue(7'd2, 4'd15, 3'd1, 24'h130010, 1'b0, 2'd0, "R6");
    drain();

    // R8 R9: request and config write while pending
    issue(7'd0, 4'd12, 3'd0, 24'h12FFF0, 1'b0, 2'd1, "R9");
    check(busy == 1, "R8", "busy while pending", 32'(busy), 1);
    req_valid = 1'b1; req_node = 7'd0; req_level = 4'd13; req_group = 3'd2;
    @(negedge clk);
    req_valid = 1'b0;
    wr(4'd0, 16'h0000);
    drain();
    check(busy == 0, "R8", "busy after strobe", 32'(busy), 0);

    // R2: new base takes effect afterwards
    issue(7'd0, 4'd3, 3'd0, 24'h120000, 1'b0, 2'd0, "R2");
    drain();

    done = 1;
    finish_run();
  end
endmodule